// File: doc/BRIEF.md
# Dual-Convention Host Register Port

This block is a synchronous register-access port for a tuner-style control block. A host reaches a small file of 8-bit registers through one shared set of pins. It can use either of two strobe conventions. In memory style, separate active-low read, write and chip enables are used. In legacy style, one chip select and one read/write direction level are used. All host pins are treated as synchronous to `clk`.

The convention is picked automatically from the read-enable pin. The pin is only looked at while the chip enable is inactive. If it is held low there, the port runs in legacy style. In that case the write-enable pin carries the direction (high = read, low = write) and the chip-enable pin acts as the select. A board that grounds the read-enable pin therefore gets the legacy behaviour with no configuration.

Two bits of the file are brought out as power-management controls. Bit 5 of register 7 disables clock-loss detection. Bit 7 of register 9 forces the power-down state. The read data bus has its own output-enable signal, so the tri-state driver can sit outside the block.

Top module: `hostreg_port`

## Requirements
- R1: While `host_ce_n` is high at a clock edge, the mode register loads legacy if `host_re_n` is low and memory if it is high. While `host_ce_n` is low, the mode is held. The mode is memory after reset.
- R2: Legacy write: the write commits at the edge where `host_ce_n` goes from low to high, provided `host_we_n` was low in the cycle before. The value written is `host_wdata` to register `host_addr`, taken in that edge's cycle.
- R3: Legacy read: while `host_ce_n` is low and `host_we_n` is high, `host_rdata_oe` is 1 and `host_rdata` equals the addressed register. Both are combinational.
- R4: Memory write: the write commits at the edge where `host_we_n` goes from low to high. `host_ce_n` must be low and `host_re_n` high in both that cycle and the one before.
- R5: Memory read: while `host_ce_n` and `host_re_n` are both low, `host_rdata_oe` is 1 and `host_rdata` equals the addressed register.
- R6: In memory mode, if `host_re_n` and `host_we_n` are low together, the access is a read (`host_rdata_oe` is 1) and no register changes.
- R7: `clk_loss_det_off` always equals bit 5 of register 7.
- R8: `pwr_down_force` always equals bit 7 of register 9.
- R9: Reset (`rst_n` low) clears every register to 0. This drives both power-management outputs to 0 and `host_rdata_oe` to 0 while the host is idle.
- R10: Every register reads back the last value written to it. When `host_rdata_oe` is 0, `host_rdata` is 0.
- R11: While `host_ce_n` stays high, toggling `host_we_n` or `host_re_n` writes nothing and never raises `host_rdata_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce_n | input | 1 | Chip enable (memory) / chip select (legacy), active low |
| host_we_n | input | 1 | Write enable (memory) / direction, 1 = read (legacy) |
| host_re_n | input | 1 | Read enable, active low; held low selects legacy mode |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Read data to host, 0 when not enabled |
| host_rdata_oe | output | 1 | Output enable for the read data driver |
| clk_loss_det_off | output | 1 | Clock-loss detection disable (reg 7 bit 5) |
| pwr_down_force | output | 1 | Forced power-down (reg 9 bit 7) |

## Verification
Read and write can meet in the same cycle in memory mode. The bench provokes this by pulling the read enable low before the write enable and then releasing the write enable while the read enable is still low. It judges the result in two ways: output enable must stay high during the overlap, and a later read must return the register's old contents. A second collision is a mode-pin change during an open legacy access. The bench raises the read enable mid-access and checks that the read drive continues.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

  typedef enum logic {
    MODE_MEM    = 1'b0,
    MODE_LEGACY = 1'b1
  } port_mode_e;

  // Read drive condition for the current strobe levels
  function automatic logic f_rd_active(input port_mode_e mode,
                                       input logic ce_n,
                                       input logic re_n,
                                       input logic we_n);
    if (mode == MODE_LEGACY) return !ce_n && we_n;
    return !ce_n && !re_n;
  endfunction

  // Write commit condition from previous and current strobe levels
  function automatic logic f_wr_commit(input port_mode_e mode,
                                       input logic prev_ce_n, input logic ce_n,
                                       input logic prev_we_n, input logic we_n,
                                       input logic prev_re_n, input logic re_n);
    if (mode == MODE_LEGACY) return !prev_ce_n && ce_n && !prev_we_n;
    return !prev_ce_n && !ce_n && !prev_we_n && we_n && prev_re_n && re_n;
  endfunction

endpackage

// File: rtl/hostreg_strobe_dec.sv
module hostreg_strobe_dec
  import hostreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       re_n,
  output port_mode_e mode,
  output logic       wr_commit,
  output logic       rd_active
);

  logic prev_ce_n, prev_we_n, prev_re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ce_n <= 1'b1;
      prev_we_n <= 1'b1;
      prev_re_n <= 1'b1;
      mode      <= MODE_MEM;
    end else begin
      prev_ce_n <= ce_n;
      prev_we_n <= we_n;
      prev_re_n <= re_n;
      if (ce_n) mode <= re_n ? MODE_MEM : MODE_LEGACY;
    end
  end

  assign wr_commit = f_wr_commit(mode, prev_ce_n, ce_n, prev_we_n, we_n, prev_re_n, re_n);
  assign rd_active = f_rd_active(mode, ce_n, re_n, we_n);

  AST_MODE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $past(ce_n)); // R1

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_active, wr_commit})); // R6

  AST_NO_SEL_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n)) |-> (!wr_commit && !rd_active)); // R11

endmodule

// File: rtl/hostreg_regfile.sv
module hostreg_regfile #(
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 8,
  parameter int CKMON_ADDR = 7,
  parameter int CKMON_BIT  = 5,
  parameter int PDOWN_ADDR = 9,
  parameter int PDOWN_BIT  = 7,
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ckmon_off,
  output logic              pdown_force
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[gi] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(gi))) regs[gi] <= wr_data;
    end
  end

  assign rd_data     = regs[rd_addr];
  assign ckmon_off   = regs[CKMON_ADDR][CKMON_BIT];
  assign pdown_force = regs[PDOWN_ADDR][PDOWN_BIT];

  AST_CKMON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(ckmon_off)); // R7

  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pdown_force)); // R8

endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hostreg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ce_n,
  input  logic              host_we_n,
  input  logic              host_re_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              clk_loss_det_off,
  output logic              pwr_down_force
);

  port_mode_e        mode;
  logic              wr_commit;
  logic              rd_active;
  logic [DATA_W-1:0] rf_rd_data;

  hostreg_strobe_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (host_ce_n),
    .we_n      (host_we_n),
    .re_n      (host_re_n),
    .mode      (mode),
    .wr_commit (wr_commit),
    .rd_active (rd_active)
  );

  hostreg_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_commit),
    .wr_addr     (host_addr),
    .wr_data     (host_wdata),
    .rd_addr     (host_addr),
    .rd_data     (rf_rd_data),
    .ckmon_off   (clk_loss_det_off),
    .pdown_force (pwr_down_force)
  );

  assign host_rdata_oe = rd_active;
  assign host_rdata    = rd_active ? rf_rd_data : '0;

  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata_oe |-> !host_ce_n); // R5

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata_oe |-> (host_rdata == '0)); // R10

  AST_MEM_NO_WR_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MEM && (!host_re_n || $past(!host_re_n))) |-> !wr_commit); // R6

endmodule

// File: tb/sim_hostreg_port.sv
module sim_hostreg_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, re_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       oe, ckoff, pdown;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostreg_port u0 (
    .clk(clk), .rst_n(rst_n), .host_ce_n(ce_n), .host_we_n(we_n), .host_re_n(re_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .host_rdata_oe(oe),
    .clk_loss_det_off(ckoff), .pwr_down_force(pdown)
  );

  // {legacy, addr[3:0], data[7:0]}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 4'd0,  8'hA5}, {1'b1, 4'd1,  8'h3C}, {1'b0, 4'd15, 8'hFF},
    {1'b1, 4'd14, 8'h01}, {1'b0, 4'd3,  8'h80}, {1'b1, 4'd4,  8'h7E},
    {1'b0, 4'd5,  8'h00}, {1'b1, 4'd11, 8'hC3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input logic legacy, input logic we_lvl);
    @(negedge clk);
    ce_n = 1'b1; re_n = ~legacy; we_n = we_lvl;
    @(negedge clk);
  endtask

  task automatic mem_write(input logic [3:0] a, input logic [7:0] d);
    idle(1'b0, 1'b1);
    ce_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic leg_write(input logic [3:0] a, input logic [7:0] d);
    idle(1'b1, 1'b0);
    ce_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic do_read(input logic legacy, input logic [3:0] a, input logic [7:0] exp,
                         input string req);
    idle(legacy, 1'b1);
    ce_n = 1'b0; re_n = 1'b0; addr = a;
    #1;
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, rdata, exp);
    @(negedge clk); ce_n = 1'b1; re_n = ~legacy;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    #(CLK_PERIOD * 2 + 1);
    chk("R9 oe", {7'd0, oe}, 8'd0);
    chk("R9 ckoff", {7'd0, ckoff}, 8'd0);
    chk("R9 pdown", {7'd0, pdown}, 8'd0);
    chk("R10 idle bus", rdata, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    do_read(1'b0, 4'd7, 8'h00, "R9 reg7");

    // Table walk: write then read back in the same convention (R2 R3 R4 R5 R10)
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][12]) leg_write(VEC[i][11:8], VEC[i][7:0]);
      else            mem_write(VEC[i][11:8], VEC[i][7:0]);
      do_read(VEC[i][12], VEC[i][11:8], VEC[i][7:0], VEC[i][12] ? "R2/R3 legacy" : "R4/R5 memory");
    end
    // cross-convention readback of all table entries (R10)
    for (int i = 0; i < 8; i++)
      do_read(~VEC[i][12], VEC[i][11:8], VEC[i][7:0], "R10 readback");

    // R7 / R8: power-management bits
    mem_write(4'd7, 8'h20);
    #1; chk("R7 set", {7'd0, ckoff}, 8'd1);
    chk("R8 untouched", {7'd0, pdown}, 8'd0);
    leg_write(4'd9, 8'h80);
    #1; chk("R8 set", {7'd0, pdown}, 8'd1);
    mem_write(4'd7, 8'hDF);
    #1; chk("R7 clear", {7'd0, ckoff}, 8'd0);
    chk("R8 held", {7'd0, pdown}, 8'd1);

    // R6: read and write low together in memory mode
    idle(1'b0, 1'b1);
    ce_n = 1'b0; addr = 4'd0; wdata = 8'h11;
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    #1; chk("R6 oe during overlap", {7'd0, oe}, 8'd1);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; re_n = 1'b1;
    do_read(1'b0, 4'd0, 8'hA5, "R6 no write");

    // R11: strobes toggle with chip enable high
    idle(1'b0, 1'b1);
    addr = 4'd1; wdata = 8'h99;
    we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; re_n = 1'b0;
    #1; chk("R11 no oe", {7'd0, oe}, 8'd0);
    @(negedge clk); re_n = 1'b1;
    do_read(1'b0, 4'd1, 8'h3C, "R11 no write");

    // R1: read-enable change mid legacy access does not switch mode
    idle(1'b1, 1'b1);
    ce_n = 1'b0; addr = 4'd14;
    @(negedge clk); re_n = 1'b1;
    @(negedge clk);
    #1; chk("R1 mode held oe", {7'd0, oe}, 8'd1);
    chk("R1 mode held data", rdata, 8'h01);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    // now idle with re_n high -> memory mode; legacy read level alone gives no drive
    ce_n = 1'b0; we_n = 1'b1;
    #1; chk("R1 memory selected", {7'd0, oe}, 8'd0);
    @(negedge clk); ce_n = 1'b1;

    // R9: reset mid-run clears registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    #1; chk("R9 pdown cleared", {7'd0, pdown}, 8'd0);
    rst_n = 1'b1;
    do_read(1'b1, 4'd15, 8'h00, "R9 reg15 cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule